// File: doc/BRIEF.md
# Fault Group Spare-Bound Early Terminator

This block sits in a memory repair flow, after rows and columns that need a spare of a fixed type have already been replaced. It takes the remaining faulty cells one per cycle as (row, column) pairs and sorts them into independent fault groups. Two faults belong to the same group when they share a row or a column, either directly or through a chain of other faults. No fault in one group shares a line with a fault in any other group.

For every group the block reports five counts: faults, distinct faulty rows, distinct faulty columns, rows that hold two or more of the group's faults (multi-fault rows), and columns that hold two or more (multi-fault columns). From the multi-fault line counts it derives a lower bound on the spares that the group needs. It then runs two unrepairability tests against the combined count of spare rows and spare columns still free. The first test compares the number of groups with that count. The second test compares the sum of the per-group bounds with it. A one-cycle done pulse marks the decision. The per-group counts are read through a group-select index.

Top module: `fault_group_terminator`

## Requirements
- R1: While idle, each cycle with `flt_valid` high stores one fault, and a fault stored with `flt_last` high ends the batch and samples `spares_avail`; `busy` is high from the next cycle until analysis ends. Faults beyond `MAX_FAULTS` in a batch are discarded. Faults in one batch must all be distinct.
- R2: `grp_total` equals the number of groups, where faults that are linked through shared rows or columns, directly or in a chain, form one group.
- R3: Groups are numbered from 0 in the order of each group's earliest-arrived fault. With `grp_sel` equal to a group's number, `sel_nf`, `sel_nfr`, `sel_nfc`, `sel_nmr` and `sel_nmc` give its fault, faulty-row, faulty-column, multi-fault-row and multi-fault-column counts. A `grp_sel` with no group gives all zeros.
- R4: A group whose multi-fault row count or multi-fault column count is zero has a spare bound (`sel_min`) of 1.
- R5: Otherwise, the direction with fewer multi-fault lines decides the bound. The bound is that multi-fault line count when it equals the faulty line count in the same direction, and that count plus one when the faulty line count is larger.
- R6: When the multi-fault row and multi-fault column counts are equal, both directions are evaluated and the bound is the smaller result.
- R7: `bound_sum` is the sum of the bounds of all groups, and it is never below `grp_total`.
- R8: At done, `term_count` is 1 exactly when `grp_total` is greater than the sampled spare count.
- R9: At done, `term_bound` is 1 exactly when `bound_sum` is greater than the sampled spare count. `terminate` is the OR of `term_count` and `term_bound`.
- R10: `done` is a one-cycle pulse in the cycle after the last `busy` cycle. The results hold until the first fault of the next batch, which clears the decision flags.
- R11: After reset, `busy`, `done`, `terminate`, `term_count`, `term_bound` and `grp_total` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault present on flt_row/flt_col |
| flt_row | input | ROW_W | Row address of the fault |
| flt_col | input | COL_W | Column address of the fault |
| flt_last | input | 1 | Marks the final fault of the batch |
| spares_avail | input | SPARE_W | Free spare rows plus free spare columns |
| grp_sel | input | IDX_W | Group whose counts are shown |
| busy | output | 1 | Group analysis in progress |
| done | output | 1 | One-cycle pulse when the decision is ready |
| terminate | output | 1 | Memory judged unrepairable |
| term_count | output | 1 | Group count exceeds the spares |
| term_bound | output | 1 | Sum of bounds exceeds the spares |
| grp_total | output | CNT_W | Number of fault groups |
| bound_sum | output | CNT_W | Sum of per-group spare bounds |
| sel_nf | output | CNT_W | Faults in the selected group |
| sel_nfr | output | CNT_W | Faulty rows in the selected group |
| sel_nfc | output | CNT_W | Faulty columns in the selected group |
| sel_nmr | output | CNT_W | Multi-fault rows in the selected group |
| sel_nmc | output | CNT_W | Multi-fault columns in the selected group |
| sel_min | output | CNT_W | Spare bound of the selected group |

## Verification
The hardest case to reach is a late fault that bridges two groups that were separate until it arrived. In that case a low group label has to travel through several faults before the grouping settles. The bench drives such a bridge, and also a seven-fault staircase in which the linking runs along a diagonal, so that label propagation has to run for several cycles. It also builds a group with equal multi-fault counts in which the row and column directions give different bounds, so that only the smaller-of-two rule keeps the decision at continue when the spares are tight.

// File: rtl/fault_group_terminator.sv
module fault_group_terminator #(
  parameter int MAX_FAULTS = 8,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int SPARE_W    = 5,
  localparam int IDX_W     = $clog2(MAX_FAULTS),
  localparam int CNT_W     = $clog2(MAX_FAULTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [ROW_W-1:0]   flt_row,
  input  logic [COL_W-1:0]   flt_col,
  input  logic               flt_last,
  input  logic [SPARE_W-1:0] spares_avail,
  input  logic [IDX_W-1:0]   grp_sel,
  output logic               busy,
  output logic               done,
  output logic               terminate,
  output logic               term_count,
  output logic               term_bound,
  output logic [CNT_W-1:0]   grp_total,
  output logic [CNT_W-1:0]   bound_sum,
  output logic [CNT_W-1:0]   sel_nf,
  output logic [CNT_W-1:0]   sel_nfr,
  output logic [CNT_W-1:0]   sel_nfc,
  output logic [CNT_W-1:0]   sel_nmr,
  output logic [CNT_W-1:0]   sel_nmc,
  output logic [CNT_W-1:0]   sel_min
);

  localparam int CMP_W = ((CNT_W > SPARE_W) ? CNT_W : SPARE_W) + 1;

  logic [ROW_W-1:0]      row_q [MAX_FAULTS];
  logic [COL_W-1:0]      col_q [MAX_FAULTS];
  logic [IDX_W-1:0]      lbl   [MAX_FAULTS];
  logic [IDX_W-1:0]      lbl_nx[MAX_FAULTS];
  logic [MAX_FAULTS-1:0] vld_q;
  logic [CNT_W-1:0]      fcnt;
  logic                  fresh, busy_q, done_q, tc_q, tb_q, changed;
  logic [SPARE_W-1:0]    spare_q;

  logic [MAX_FAULTS-1:0] row_first, col_first, row_dup, col_dup, is_root;
  logic [CNT_W-1:0] nf_g [MAX_FAULTS];
  logic [CNT_W-1:0] nfr_g[MAX_FAULTS];
  logic [CNT_W-1:0] nfc_g[MAX_FAULTS];
  logic [CNT_W-1:0] nmr_g[MAX_FAULTS];
  logic [CNT_W-1:0] nmc_g[MAX_FAULTS];
  logic [CNT_W-1:0] min_g[MAX_FAULTS];

  function automatic logic [CNT_W-1:0] spare_bound(
    input logic [CNT_W-1:0] mr, input logic [CNT_W-1:0] mc,
    input logic [CNT_W-1:0] fr, input logic [CNT_W-1:0] fc);
    logic [CNT_W-1:0] r, c;
    r = (mr == fr) ? mr : mr + CNT_W'(1);
    c = (mc == fc) ? mc : mc + CNT_W'(1);
    if (mr == '0 || mc == '0) return CNT_W'(1);
    if (mr < mc) return r;
    if (mc < mr) return c;
    return (r < c) ? r : c;
  endfunction

  // label relaxation: every fault takes the smallest label among its line neighbours
  always_comb begin
    changed = 1'b0;
    for (int i = 0; i < MAX_FAULTS; i++) begin
      lbl_nx[i] = lbl[i];
      for (int j = 0; j < MAX_FAULTS; j++)
        if (vld_q[i] && vld_q[j] && (row_q[i] == row_q[j] || col_q[i] == col_q[j])
            && lbl[j] < lbl_nx[i])
          lbl_nx[i] = lbl[j];
      if (lbl_nx[i] != lbl[i]) changed = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_FAULTS; i++) begin
      row_first[i] = vld_q[i];
      col_first[i] = vld_q[i];
      row_dup[i]   = 1'b0;
      col_dup[i]   = 1'b0;
      for (int j = 0; j < MAX_FAULTS; j++) begin
        if (j != i && vld_q[i] && vld_q[j]) begin
          if (row_q[i] == row_q[j]) begin
            row_dup[i] = 1'b1;
            if (j < i) row_first[i] = 1'b0;
          end
          if (col_q[i] == col_q[j]) begin
            col_dup[i] = 1'b1;
            if (j < i) col_first[i] = 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < MAX_FAULTS; g++) begin
      is_root[g] = vld_q[g] && (lbl[g] == IDX_W'(g));
      nf_g[g] = '0; nfr_g[g] = '0; nfc_g[g] = '0; nmr_g[g] = '0; nmc_g[g] = '0;
      for (int i = 0; i < MAX_FAULTS; i++) begin
        if (vld_q[i] && lbl[i] == IDX_W'(g)) begin
          nf_g[g] = nf_g[g] + CNT_W'(1);
          if (row_first[i]) nfr_g[g] = nfr_g[g] + CNT_W'(1);
          if (col_first[i]) nfc_g[g] = nfc_g[g] + CNT_W'(1);
          if (row_first[i] && row_dup[i]) nmr_g[g] = nmr_g[g] + CNT_W'(1);
          if (col_first[i] && col_dup[i]) nmc_g[g] = nmc_g[g] + CNT_W'(1);
        end
      end
      min_g[g] = spare_bound(nmr_g[g], nmc_g[g], nfr_g[g], nfc_g[g]);
    end
  end

  always_comb begin
    logic [CNT_W-1:0] rank;
    rank = '0;
    grp_total = '0;
    bound_sum = '0;
    sel_nf = '0; sel_nfr = '0; sel_nfc = '0; sel_nmr = '0; sel_nmc = '0; sel_min = '0;
    for (int g = 0; g < MAX_FAULTS; g++) begin
      if (is_root[g]) begin
        if (rank == CNT_W'(grp_sel)) begin
          sel_nf  = nf_g[g];
          sel_nfr = nfr_g[g];
          sel_nfc = nfc_g[g];
          sel_nmr = nmr_g[g];
          sel_nmc = nmc_g[g];
          sel_min = min_g[g];
        end
        rank      = rank + CNT_W'(1);
        bound_sum = bound_sum + min_g[g];
      end
    end
    grp_total = rank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      fcnt    <= '0;
      fresh   <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      tc_q    <= 1'b0;
      tb_q    <= 1'b0;
      spare_q <= '0;
      for (int i = 0; i < MAX_FAULTS; i++) begin
        row_q[i] <= '0;
        col_q[i] <= '0;
        lbl[i]   <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        for (int i = 0; i < MAX_FAULTS; i++) lbl[i] <= lbl_nx[i];
        if (!changed) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          fresh  <= 1'b1;
          tc_q   <= CMP_W'(grp_total) > CMP_W'(spare_q);
          tb_q   <= CMP_W'(bound_sum) > CMP_W'(spare_q);
        end
      end else if (flt_valid) begin
        if (fresh) begin
          vld_q    <= MAX_FAULTS'(1);
          row_q[0] <= flt_row;
          col_q[0] <= flt_col;
          lbl[0]   <= '0;
          fcnt     <= CNT_W'(1);
          fresh    <= 1'b0;
          tc_q     <= 1'b0;
          tb_q     <= 1'b0;
        end else if (fcnt < CNT_W'(MAX_FAULTS)) begin
          vld_q[fcnt[IDX_W-1:0]] <= 1'b1;
          row_q[fcnt[IDX_W-1:0]] <= flt_row;
          col_q[fcnt[IDX_W-1:0]] <= flt_col;
          lbl[fcnt[IDX_W-1:0]]   <= fcnt[IDX_W-1:0];
          fcnt                   <= fcnt + CNT_W'(1);
        end
        if (flt_last) begin
          busy_q  <= 1'b1;
          spare_q <= spares_avail;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign term_count = tc_q;
  assign term_bound = tb_q;
  assign terminate  = tc_q | tb_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R7
  bound_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> bound_sum >= grp_total);
  // R9
  count_implies_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && term_count) |-> term_bound);
  // R1
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n) fcnt <= CNT_W'(MAX_FAULTS));
  // R2
  groups_le_faults_chk: assert property (@(posedge clk) disable iff (!rst_n) grp_total <= fcnt);

endmodule

// File: tb/fault_group_terminator_tb.sv
module fault_group_terminator_tb;
  localparam int MAXF = 8, RW = 4, CW = 4, SW = 5, IW = 3, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_valid = 1'b0, flt_last = 1'b0;
  logic [RW-1:0] flt_row = '0;
  logic [CW-1:0] flt_col = '0;
  logic [SW-1:0] spares_avail = '0;
  logic [IW-1:0] grp_sel = '0;
  logic busy, done, terminate, term_count, term_bound;
  logic [NW-1:0] grp_total, bound_sum, sel_nf, sel_nfr, sel_nfc, sel_nmr, sel_nmc, sel_min;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fault_group_terminator #(.MAX_FAULTS(MAXF), .ROW_W(RW), .COL_W(CW), .SPARE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_row(flt_row), .flt_col(flt_col),
    .flt_last(flt_last), .spares_avail(spares_avail), .grp_sel(grp_sel), .busy(busy),
    .done(done), .terminate(terminate), .term_count(term_count), .term_bound(term_bound),
    .grp_total(grp_total), .bound_sum(bound_sum), .sel_nf(sel_nf), .sel_nfr(sel_nfr),
    .sel_nfc(sel_nfc), .sel_nmr(sel_nmr), .sel_nmc(sel_nmc), .sel_min(sel_min));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int r, input int c, input bit last);
    flt_valid = 1'b1; flt_row = RW'(r); flt_col = CW'(c); flt_last = last;
    @(negedge clk);
    flt_valid = 1'b0; flt_last = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R10 done seen", int'(done), 1);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
  endtask

  task automatic grp(input int g, input int nf, input int fr, input int fc,
                     input int mr, input int mc, input int mn);
    grp_sel = IW'(g);
    #1;
    chk("R3 nf", int'(sel_nf), nf);
    chk("R3 nfr", int'(sel_nfr), fr);
    chk("R3 nfc", int'(sel_nfc), fc);
    chk("R3 nmr", int'(sel_nmr), mr);
    chk("R3 nmc", int'(sel_nmc), mc);
    chk("R4 R5 R6 bound", int'(sel_min), mn);
  endtask

  task automatic decision(input int gt, input int bs, input int tc, input int tb);
    chk("R2 grp_total", int'(grp_total), gt);
    chk("R7 bound_sum", int'(bound_sum), bs);
    chk("R8 term_count", int'(term_count), tc);
    chk("R9 term_bound", int'(term_bound), tb);
    chk("R9 terminate", int'(terminate), tc | tb);
  endtask

  task automatic t_reset();
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 terminate", int'(terminate), 0);
    chk("R11 term_count", int'(term_count), 0);
    chk("R11 term_bound", int'(term_bound), 0);
    chk("R11 grp_total", int'(grp_total), 0);
  endtask

  task automatic t_single();
    spares_avail = 5'd1;
    send(1, 1, 1'b1);
    chk("R1 busy after last", int'(busy), 1);
    wait_done();
    chk("R1 busy cleared", int'(busy), 0);
    decision(1, 1, 0, 0);
    grp(0, 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_row_line();
    spares_avail = 5'd1;
    send(2, 1, 1'b0); send(2, 5, 1'b0); send(2, 7, 1'b1);
    wait_done();
    decision(1, 1, 0, 0);
    grp(0, 3, 1, 3, 1, 0, 1);
  endtask

  task automatic t_two_groups(input int sp, input int tb);
    spares_avail = SW'(sp);
    send(0, 0, 1'b0); send(0, 2, 1'b0); send(1, 0, 1'b0); send(1, 3, 1'b0);
    send(5, 5, 1'b1);
    wait_done();
    decision(2, 3, 0, tb);
    grp(0, 4, 2, 3, 2, 1, 2);
    grp(1, 1, 1, 1, 0, 0, 1);
    grp(2, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bridge();
    spares_avail = 5'd2;
    send(0, 0, 1'b0); send(5, 5, 1'b0); send(0, 5, 1'b1);
    wait_done();
    decision(1, 2, 0, 0);
    grp(0, 3, 2, 2, 1, 1, 2);
  endtask

  task automatic t_tie_asym();
    spares_avail = 5'd2;
    send(10, 0, 1'b0); send(11, 0, 1'b0); send(10, 1, 1'b0); send(11, 1, 1'b0);
    send(10, 2, 1'b1);
    wait_done();
    decision(1, 2, 0, 0);
    grp(0, 5, 2, 3, 2, 2, 2);
  endtask

  task automatic t_many_groups();
    spares_avail = 5'd2;
    send(1, 1, 1'b0); send(2, 2, 1'b0); send(3, 3, 1'b1);
    wait_done();
    decision(3, 3, 1, 1);
    grp(2, 1, 1, 1, 0, 0, 1);
    grp(3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stair(input int sp, input int tb);
    spares_avail = SW'(sp);
    send(0, 0, 1'b0); send(1, 1, 1'b0); send(2, 2, 1'b0); send(3, 3, 1'b0);
    send(2, 3, 1'b0); send(1, 2, 1'b0); send(0, 1, 1'b1);
    wait_done();
    decision(1, 4, 0, tb);
    grp(0, 7, 4, 4, 3, 3, 4);
  endtask

  task automatic t_overflow();
    spares_avail = 5'd8;
    for (int k = 0; k < 8; k++) send(k, k, 1'b0);
    send(9, 9, 1'b1);
    wait_done();
    decision(8, 8, 0, 0);
    grp(7, 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_flags_clear();
    spares_avail = 5'd2;
    send(1, 1, 1'b0); send(2, 2, 1'b0); send(3, 3, 1'b1);
    wait_done();
    chk("R10 terminate held", int'(terminate), 1);
    send(4, 4, 1'b0);
    chk("R10 flags cleared by new batch", int'(terminate), 0);
    send(4, 6, 1'b1);
    wait_done();
    decision(1, 1, 0, 0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_row_line();
        t_two_groups(3, 0);
        t_two_groups(2, 1);
        t_bridge();
        t_tie_asym();
        t_many_groups();
        t_stair(4, 0);
        t_stair(3, 1);
        t_overflow();
        t_flags_clear();
      end
      begin
        while (wd < 20000) begin
          @(negedge clk);
          wd++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=0", wd);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule